// File: doc/BRIEF.md
# Serial Command-Chain Transaction Engine

This block carries out one complete command and reply exchange with an external filter controller over a four-wire serial link. The link has an active-low select, a clock, a data line towards the controller and a data line back from it. Each byte is its own full-duplex transfer inside its own select frame. All gaps and half-periods are counted in system clock cycles, derived from microsecond parameters and a clocks-per-microsecond parameter.

A host places a zero-terminated ASCII command of up to `BUF_LEN` bytes on `cmd_i` (byte i at bits 8i+7..8i) and pulses `start_i`. The engine first sends two zero bytes. If the second of these returns a nonzero value, it sends more zero bytes to drain stale replies. It then sends the command bytes, a zero terminator and waits a long settling time. Next it sends a lead zero byte, waits a trailing gap and reads reply bytes until one of them is zero. At the end it pulses `done_o`, with `err_o`, `rx_cnt_o` and `rx_buf_o` valid.

Top module: `cmd_chain_xfer`

## Requirements
- R1: After reset, `cs_no` is high and `sclk_o` and `mosi_o` are low, and `busy_o` stays high for TRAIL_US*CLK_PER_US cycles. Whenever `busy_o` is low, the link lines hold those idle levels.
- R2: A byte transfer is a pre-write gap of PRE_US followed by 27 half-ticks of HALF_US each: clock low, select falls, three half-ticks per bit, then select high. This makes `cs_no` low for exactly 25 half-ticks, and `sclk_o` high only while `cs_no` is low.
- R3: `mosi_o` carries the byte MSB first and is stable while `sclk_o` is high. `miso_i` is sampled at the end of each high half-tick, and the first sampled bit becomes bit 7 of the received byte.
- R4: A transaction opens with two zero-byte transfers. The value returned by the first one is ignored.
- R5: If the second opening transfer returns nonzero, zero bytes are sent until one returns zero, at most FLUSH_MAX of them. If all FLUSH_MAX return nonzero, the transaction ends at once with `err_o` high.
- R6: Command bytes are sent in index order, stopping before the first zero byte or after BUF_LEN bytes. One zero byte follows, and then a settle wait of SETTLE_US.
- R7: The reply phase sends one zero byte, waits TRAIL_US, then reads with zero bytes. A TRAIL_US gap follows each nonzero byte read. The phase stops at the first zero byte read or after BUF_LEN-1 nonzero bytes.
- R8: On start, `rx_buf_o` and `rx_cnt_o` are cleared. Nonzero reply bytes are stored in order from slot 0, and `rx_cnt_o` gives their number. Unused slots read zero.
- R9: `done_o` is high for exactly one cycle, and `err_o` is valid in that cycle. Counting from the cycle in which start is taken, done comes nb*T + Wsum + 1 cycles later. Here nb is the number of transfers, T is the transfer length in cycles, and Wsum is the total of the settle and trailing waits.
- R10: `start_i` is ignored while `busy_o` is high. The command is captured when start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction when idle |
| cmd_i | input | 8*BUF_LEN | Command bytes, byte i at bits 8i+7..8i |
| busy_o | output | 1 | Transaction or power-up gap in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Flush limit hit, valid with done_o |
| rx_cnt_o | output | $clog2(BUF_LEN) | Number of reply bytes captured |
| rx_buf_o | output | 8*(BUF_LEN-1) | Reply bytes, slot i at bits 8i+7..8i |
| cs_no | output | 1 | Serial select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to controller |
| miso_i | input | 1 | Serial data from controller |

## Verification
The bench records the cycle in which start is taken. From the script it builds for that transaction, it computes the exact cycle in which `done_o` must rise. It samples on falling clock edges and compares that cycle number, then checks that `done_o` is low one cycle later. The select width is measured in simulation time against 25 half-ticks for every frame. The byte stream is captured on rising serial clocks and compared with the expected sequence once the transaction has ended, so these checks do not depend on any design timing inside the frame.

// File: rtl/cce_pkg.sv
package cce_pkg;
  typedef enum logic [3:0] {
    SQ_INIT, SQ_IDLE, SQ_PRE, SQ_CMD, SQ_TERM,
    SQ_SETTLE, SQ_LEAD, SQ_LEADGAP, SQ_READ, SQ_READGAP
  } seq_st_e;

  typedef enum logic [2:0] {
    BX_IDLE, BX_PRE, BX_CK0, BX_CSL, BX_DSET, BX_CKH, BX_CKL, BX_CSH
  } bx_st_e;
endpackage

// File: rtl/cce_delay.sv
module cce_delay #(
  parameter int W      = 8,
  parameter int RST_LD = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= W'(RST_LD);
    else if (load_i)           cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cce_byte_xfer.sv
module cce_byte_xfer import cce_pkg::*; #(
  parameter int PRE_CYC  = 7500,
  parameter int HALF_CYC = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       cs_no,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int MAXC = (PRE_CYC > HALF_CYC) ? PRE_CYC : HALF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);

  bx_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;
  logic          last, accept;

  assign last   = (cnt_q == '0);
  assign done_o = (st_q == BX_CSH) && last;
  // back-to-back transfers: a new go may be taken in the finishing cycle
  assign accept = go_i && ((st_q == BX_IDLE) || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (accept) begin
      st_q  <= BX_PRE;
      cnt_q <= PRE_LD;
      bit_q <= '0;
      tx_q  <= tx_i;
    end else if (st_q != BX_IDLE) begin
      if (!last) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= HALF_LD;
        case (st_q)
          BX_PRE:  st_q <= BX_CK0;
          BX_CK0:  st_q <= BX_CSL;
          BX_CSL:  st_q <= BX_DSET;
          BX_DSET: st_q <= BX_CKH;
          BX_CKH: begin
            st_q <= BX_CKL;
            rx_q <= {rx_q[6:0], miso_i};
          end
          BX_CKL: begin
            if (bit_q == 3'd7) begin
              st_q <= BX_CSH;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
              st_q  <= BX_DSET;
            end
          end
          default: st_q <= BX_IDLE;
        endcase
      end
    end
  end

  assign cs_no  = !(st_q inside {BX_CSL, BX_DSET, BX_CKH, BX_CKL});
  assign sclk_o = (st_q == BX_CKH);
  assign mosi_o = (st_q inside {BX_DSET, BX_CKH, BX_CKL}) && tx_q[7];
  assign rx_o   = rx_q;
endmodule

// File: rtl/cce_chain_seq.sv
module cce_chain_seq import cce_pkg::*; #(
  parameter int BUF_LEN    = 10,
  parameter int FLUSH_MAX  = 42,
  parameter int DW         = 21,
  parameter int SETTLE_LEN = 2000000,
  parameter int TRAIL_LEN  = 20000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [8*BUF_LEN-1:0]       cmd_i,
  input  logic                       bdone_i,
  input  logic [7:0]                 brx_i,
  output logic                       bgo_o,
  output logic [7:0]                 btx_o,
  input  logic                       dexp_i,
  output logic                       dld_o,
  output logic [DW-1:0]              dlen_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [$clog2(BUF_LEN)-1:0] rx_cnt_o,
  output logic [8*(BUF_LEN-1)-1:0]   rx_buf_o
);
  localparam int IDX_W = $clog2(BUF_LEN + 1);
  localparam int CNT_W = $clog2(BUF_LEN);
  localparam int PC_W  = $clog2(FLUSH_MAX + 2);
  localparam logic [PC_W-1:0]  PC_LAST = PC_W'(FLUSH_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_LEN - 1);

  seq_st_e          st_q, st_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_n;
  logic [CNT_W-1:0] cnt_q;
  logic [8*BUF_LEN-1:0] cmd_q;
  logic [7:0]       cmd_a [BUF_LEN+1];
  logic [7:0]       buf_q [BUF_LEN-1];
  logic             done_q, err_q, fin, ferr, wr, clr;

  always_comb begin
    for (int i = 0; i < BUF_LEN; i++) cmd_a[i] = cmd_q[i*8 +: 8];
    cmd_a[BUF_LEN] = 8'h00;
  end
  assign idx_n = idx_q + IDX_W'(1);

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    idx_d  = idx_q;
    bgo_o  = 1'b0;
    btx_o  = 8'h00;
    dld_o  = 1'b0;
    dlen_o = DW'(TRAIL_LEN);
    fin    = 1'b0;
    ferr   = 1'b0;
    wr     = 1'b0;
    clr    = 1'b0;
    case (st_q)
      SQ_INIT: if (dexp_i) st_d = SQ_IDLE;
      SQ_IDLE: if (start_i) begin
        bgo_o = 1'b1; st_d = SQ_PRE; pc_d = '0; clr = 1'b1;
      end
      SQ_PRE: if (bdone_i) begin
        if (pc_q == '0 || (brx_i != 8'h00 && pc_q != PC_LAST)) begin
          bgo_o = 1'b1; pc_d = pc_q + PC_W'(1);
        end else if (brx_i != 8'h00) begin
          fin = 1'b1; ferr = 1'b1;
        end else begin
          bgo_o = 1'b1; idx_d = '0;
          if (cmd_a[0] != 8'h00) begin
            btx_o = cmd_a[0]; st_d = SQ_CMD;
          end else st_d = SQ_TERM;
        end
      end
      SQ_CMD: if (bdone_i) begin
        bgo_o = 1'b1;
        if (cmd_a[idx_n] == 8'h00) st_d = SQ_TERM;
        else begin btx_o = cmd_a[idx_n]; idx_d = idx_n; end
      end
      SQ_TERM: if (bdone_i) begin
        dld_o = 1'b1; dlen_o = DW'(SETTLE_LEN); st_d = SQ_SETTLE;
      end
      SQ_SETTLE:  if (dexp_i)  begin bgo_o = 1'b1; st_d = SQ_LEAD; end
      SQ_LEAD:    if (bdone_i) begin dld_o = 1'b1; st_d = SQ_LEADGAP; end
      SQ_LEADGAP: if (dexp_i)  begin bgo_o = 1'b1; st_d = SQ_READ; end
      SQ_READ: if (bdone_i) begin
        if (brx_i == 8'h00) fin = 1'b1;
        else begin wr = 1'b1; dld_o = 1'b1; st_d = SQ_READGAP; end
      end
      SQ_READGAP: if (dexp_i) begin
        if (cnt_q == CNT_MAX) fin = 1'b1;
        else begin bgo_o = 1'b1; st_d = SQ_READ; end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (fin) st_d = SQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_INIT;
      pc_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      for (int i = 0; i < BUF_LEN-1; i++) buf_q[i] <= 8'h00;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      idx_q  <= idx_d;
      done_q <= fin;
      err_q  <= ferr;
      if (clr) begin
        cmd_q <= cmd_i;
        cnt_q <= '0;
        for (int i = 0; i < BUF_LEN-1; i++) buf_q[i] <= 8'h00;
      end else if (wr) begin
        buf_q[cnt_q] <= brx_i;
        cnt_q        <= cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < BUF_LEN-1; g++) begin : g_flat
    assign rx_buf_o[g*8 +: 8] = buf_q[g];
  end

  assign busy_o   = (st_q != SQ_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rx_cnt_o = cnt_q;
endmodule

// File: rtl/cmd_chain_xfer.sv
module cmd_chain_xfer #(
  parameter int CLK_PER_US = 100,
  parameter int PRE_US     = 75,
  parameter int HALF_US    = 100,
  parameter int TRAIL_US   = 200,
  parameter int SETTLE_US  = 20000,
  parameter int FLUSH_MAX  = 42,
  parameter int BUF_LEN    = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [8*BUF_LEN-1:0]       cmd_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [$clog2(BUF_LEN)-1:0] rx_cnt_o,
  output logic [8*(BUF_LEN-1)-1:0]   rx_buf_o,
  output logic                       cs_no,
  output logic                       sclk_o,
  output logic                       mosi_o,
  input  logic                       miso_i
);
  localparam int PRE_CYC    = PRE_US * CLK_PER_US;
  localparam int HALF_CYC   = HALF_US * CLK_PER_US;
  localparam int TRAIL_CYC  = TRAIL_US * CLK_PER_US;
  localparam int SETTLE_CYC = SETTLE_US * CLK_PER_US;
  localparam int MAXW       = (SETTLE_CYC > TRAIL_CYC) ? SETTLE_CYC : TRAIL_CYC;
  localparam int DW         = $clog2(MAXW + 1);

  logic          bgo, bdone, dld, dexp;
  logic [7:0]    btx, brx;
  logic [DW-1:0] dlen;

  cce_chain_seq #(
    .BUF_LEN(BUF_LEN), .FLUSH_MAX(FLUSH_MAX), .DW(DW),
    .SETTLE_LEN(SETTLE_CYC), .TRAIL_LEN(TRAIL_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .cmd_i,
    .bdone_i(bdone), .brx_i(brx), .bgo_o(bgo), .btx_o(btx),
    .dexp_i(dexp), .dld_o(dld), .dlen_o(dlen),
    .busy_o, .done_o, .err_o, .rx_cnt_o, .rx_buf_o
  );

  cce_byte_xfer #(.PRE_CYC(PRE_CYC), .HALF_CYC(HALF_CYC)) u_bx (
    .clk_i, .rst_ni, .go_i(bgo), .tx_i(btx), .done_o(bdone), .rx_o(brx),
    .cs_no, .sclk_o, .mosi_o, .miso_i
  );

  cce_delay #(.W(DW), .RST_LD(TRAIL_CYC - 1)) u_dly (
    .clk_i, .rst_ni, .load_i(dld), .len_i(dlen), .expired_o(dexp)
  );
endmodule

// File: rtl/cmd_chain_xfer_chk.sv
module cmd_chain_xfer_chk #(
  parameter int BUF_LEN = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       busy_o,
  input logic                       done_o,
  input logic                       cs_no,
  input logic                       sclk_o,
  input logic                       mosi_o,
  input logic [$clog2(BUF_LEN)-1:0] rx_cnt_o
);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o && !mosi_o));

  a_r2_clk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  a_r3_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rx_cnt_o) <= BUF_LEN - 1);
endmodule

bind cmd_chain_xfer cmd_chain_xfer_chk #(.BUF_LEN(BUF_LEN)) u_chk (.*);

// File: tb/cmd_chain_xfer_test.sv
`timescale 1ns/1ps
module cmd_chain_xfer_test;
  localparam int BL = 10, FM = 42, CPU = 2;
  localparam int PRE = 3, HALF = 2, TRAIL = 5, SETTLE = 40;
  localparam int P = PRE*CPU, H = HALF*CPU, T = P + 27*H;
  localparam int TW = TRAIL*CPU, SW = SETTLE*CPU;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, miso_i = 1'b0;
  logic [8*BL-1:0] cmd_i = '0;
  logic busy_o, done_o, err_o, cs_no, sclk_o, mosi_o;
  logic [$clog2(BL)-1:0] rx_cnt_o;
  logic [8*(BL-1)-1:0] rx_buf_o;

  cmd_chain_xfer #(.CLK_PER_US(CPU), .PRE_US(PRE), .HALF_US(HALF), .TRAIL_US(TRAIL),
    .SETTLE_US(SETTLE), .FLUSH_MAX(FM), .BUF_LEN(BL)) uut (
    .clk_i(clk), .rst_ni, .start_i, .cmd_i, .busy_o, .done_o, .err_o,
    .rx_cnt_o, .rx_buf_o, .cs_no, .sclk_o, .mosi_o, .miso_i);

  always #2.5 clk = ~clk;

  int cyc = 0, n_run = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc == 190000) begin
    n_run++; n_fail++;
    $display("FAIL R9 watchdog act=%0d exp<%0d", cyc, 190000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // controller model
  logic [7:0] script [80];
  logic [7:0] sent   [80];
  logic [7:0] sh_o, sh_i;
  int xi = 0, cs_bad = 0;
  time t_cs;

  always @(negedge cs_no) if (rst_ni) begin
    t_cs = $time; sh_o = script[xi]; miso_i = sh_o[7];
  end
  always @(negedge sclk_o) if (rst_ni && !cs_no) begin
    sh_o = {sh_o[6:0], 1'b0}; miso_i = sh_o[7];
  end
  always @(posedge sclk_o) sh_i = {sh_i[6:0], mosi_o};
  always @(posedge cs_no) if (rst_ni) begin
    if (($time - t_cs) != time'(25*H*5)) cs_bad++;
    if (xi < 80) sent[xi] = sh_i;
    xi++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nz();
    return 8'(($urandom % 255) + 1);
  endfunction

  function automatic int exp_cycles(input int nb, input int wsum);
    return nb*T + wsum + 1;
  endfunction

  task automatic run_txn(input int ncmd, input int nfl, input bit ferr, input int rlen, input bit poke);
    logic [8*BL-1:0] cmd;
    logic [7:0] exp_sent [80];
    logic [7:0] rep [BL];
    int k, nf, ws, t0, t1, bad;
    bit e_err;
    logic [$clog2(BL)-1:0] g_cnt;
    logic [8*(BL-1)-1:0] g_buf;
    for (int i = 0; i < 80; i++) begin script[i] = 8'h00; exp_sent[i] = 8'h00; end
    for (int i = 0; i < BL; i++) begin
      rep[i] = 8'h00;
      cmd[i*8 +: 8] = (i < ncmd) ? nz() : ((i == ncmd) ? 8'h00 : nz());
    end
    script[0] = 8'($urandom % 256);
    script[1] = (nfl > 0 || ferr) ? nz() : 8'h00;
    k = 2;
    nf = ferr ? FM : nfl;
    for (int j = 0; j < nf; j++) begin
      script[k] = (ferr || j < nf-1) ? nz() : 8'h00; k++;
    end
    ws = 0;
    if (!ferr) begin
      for (int i = 0; i < ncmd; i++) begin
        exp_sent[k] = cmd[i*8 +: 8]; script[k] = 8'($urandom % 256); k++;
      end
      script[k] = 8'($urandom % 256); k++;
      script[k] = 8'($urandom % 256); k++;
      for (int i = 0; i < rlen; i++) begin rep[i] = nz(); script[k] = rep[i]; k++; end
      if (rlen < BL-1) begin script[k] = 8'h00; k++; end
      ws = SW + TW + rlen*TW;
    end
    @(negedge clk);
    cmd_i = cmd; start_i = 1'b1; xi = 0; cs_bad = 0; t0 = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      cmd_i = ~cmd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    t1 = cyc; e_err = err_o; g_cnt = rx_cnt_o; g_buf = rx_buf_o;
    chk(t1 - t0 == exp_cycles(k, ws), "R9 done cycle", t1 - t0, exp_cycles(k, ws));
    chk(e_err == ferr, "R5 err flag", e_err, ferr);
    chk(int'(g_cnt) == (ferr ? 0 : rlen), "R8 reply count", g_cnt, ferr ? 0 : rlen);
    bad = 0;
    for (int i = 0; i < BL-1; i++) if (g_buf[i*8 +: 8] != rep[i]) bad++;
    chk(bad == 0, "R7 reply bytes", bad, 0);
    chk(xi == k, "R6 transfer count", xi, k);
    bad = 0;
    for (int i = 0; i < k && i < 80; i++) if (sent[i] != exp_sent[i]) bad++;
    chk(bad == 0, "R4 sent stream (R3 bit order)", bad, 0);
    chk(cs_bad == 0, "R2 select width", cs_bad, 0);
    if (poke) chk(xi == k, "R10 start ignored when busy", xi, k);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done width", done_o, 0);
  endtask

  initial begin
    int tb;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 80; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o && cs_no && !sclk_o && !mosi_o && !done_o, "R1 reset state",
        {busy_o, cs_no, sclk_o, mosi_o, done_o}, 5'b11000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tb = 1;
    while (busy_o && tb < TW + 5) begin @(negedge clk); tb++; end
    chk(tb == TW - 1, "R1 power-up gap", tb, TW - 1);
    repeat (20) @(negedge clk);
    chk(xi == 0 && !busy_o, "R10 start during power-up ignored", xi, 0);

    run_txn(3, 0, 0, 2, 0);        // basic
    run_txn(0, 0, 0, 0, 0);        // empty command, empty reply
    run_txn(BL, 0, 0, BL-1, 0);    // full command, full reply
    run_txn(4, 1, 0, 3, 1);        // one flush, start poked while busy
    run_txn(2, FM, 0, 1, 0);       // flush limit reached with final zero
    run_txn(5, 0, 1, 0, 0);        // flush never clears
    for (int r = 0; r < 10; r++)
      run_txn($urandom % (BL+1), $urandom % 6, 0, $urandom % BL, r[0]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule